// File: doc/BRIEF.md
# Strip-Mined Strided Vector Address Generator

This block sequences a single vector memory transfer of any total element count N on a machine whose vector registers hold at most 64 elements. A start pulse captures N, a 24-bit base address and a 24-bit stride. The block then splits the transfer into strips. The short strip of N mod 64 elements runs first. Every strip after it holds exactly 64 elements.

At the start of each strip the block announces the strip length with a one-cycle pulse. It then presents one element address per accepted handshake. The k-th element of the whole transfer, counted from zero across all strips, lives at base + k * stride, taken modulo 2^24. A stride of 1 walks consecutive words. A larger stride steps down a column of a row-major array.

A one-cycle done pulse closes the transfer. A start request that arrives while a transfer is running is dropped.

Top module: `vec_strip_agen`

## Requirements
- R1: While reset is held and in the first cycle after it, addr_valid_o, strip_start_o and done_o are low and strip_len_o is zero.
- R2: When N mod 64 is nonzero, the first strip has length N mod 64. It is followed by floor(N/64) strips of length 64. strip_len_o holds the current strip's length through all of that strip's element cycles, and each strip yields exactly that many accepted addresses.
- R3: When N mod 64 is zero, no zero-length strip is announced and the first strip is a full one. When N is 0, no strip and no address appear, and done_o rises in the second cycle after the start cycle.
- R4: The k-th accepted address of a transfer equals base + k * stride modulo 2^24, with k counted from zero across strip boundaries and never reset to the base at a new strip.
- R5: The address advances only in a cycle where addr_valid_o and mem_ready_i are both high. While ready is low, the address and valid hold.
- R6: done_o is high for exactly one cycle per transfer, in the cycle right after the final element is accepted.
- R7: start_i is ignored unless the block is idle. A start during a transfer changes neither the addresses, the strips nor the done timing of that transfer.
- R8: strip_start_o is a one-cycle pulse with addr_valid_o low. The first pulse comes in the second cycle after the start cycle. Element addresses begin in the cycle right after each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled only when idle |
| total_len_i | input | 16 | Total element count N |
| base_i | input | 24 | Address of element 0 |
| stride_i | input | 24 | Address step between elements |
| mem_ready_i | input | 1 | Memory accepts the presented address |
| addr_o | output | 24 | Current element address |
| addr_valid_o | output | 1 | addr_o is presented to memory |
| strip_len_o | output | 7 | Length of the current strip (1 to 64) |
| strip_start_o | output | 1 | One-cycle pulse announcing a new strip |
| done_o | output | 1 | One-cycle pulse after the final element |

## Verification
Lengths are swept across the boundaries that change the strip layout. The set is 0, 1, 2, 63, 64, 65, 127, 128, 129 and 200. These values separate a lone remainder, exact multiples with no remainder, and a remainder followed by several full strips.

Each length runs with unit stride, a stride of 3, and an all-ones stride that counts downward. The base sits either at zero or just below the top of the address space, so the modulo wrap shows up mid-strip and across strip boundaries.

Ready is held high, dropped every third cycle, or toggled every cycle. These patterns separate a design that steps on every valid cycle from one that steps only on a completed handshake.

One run pulses start in the middle of a transfer to show that the request is dropped.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_ANNOUNCE,
    ST_STREAM,
    ST_DONE
  } vsa_state_e;
endpackage

// File: rtl/vsa_strip_plan.sv
module vsa_strip_plan #(
  parameter int LEN_W = 16,
  parameter int MVL   = 64,
  localparam int SH    = $clog2(MVL),
  localparam int VL_W  = SH + 1,
  localparam int CNT_W = LEN_W - SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] n_i,
  input  logic             take_i,
  output logic             any_left_o,
  output logic [VL_W-1:0]  next_len_o
);

  function automatic logic [SH-1:0] short_part(input logic [LEN_W-1:0] n);
    return n[SH-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] full_part(input logic [LEN_W-1:0] n);
    return n[LEN_W-1:SH];
  endfunction

  logic             short_pend_q;
  logic [SH-1:0]    short_len_q;
  logic [CNT_W-1:0] full_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      short_pend_q <= 1'b0;
      short_len_q  <= '0;
      full_cnt_q   <= '0;
    end else if (load_i) begin
      short_len_q  <= short_part(n_i);
      short_pend_q <= (short_part(n_i) != '0);
      full_cnt_q   <= full_part(n_i);
    end else if (take_i) begin
      if (short_pend_q) short_pend_q <= 1'b0;
      else if (full_cnt_q != '0) full_cnt_q <= full_cnt_q - 1'b1;
    end
  end

  always_comb begin
    any_left_o = short_pend_q || (full_cnt_q != '0);
    next_len_o = short_pend_q ? {1'b0, short_len_q} : VL_W'(MVL);
  end

endmodule

// File: rtl/vsa_addr_walk.sv
module vsa_addr_walk #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] stride_o
);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] s);
    return a + s;
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      addr_q   <= base_i;
      stride_q <= stride_i;
    end else if (step_i) begin
      addr_q <= step_addr(addr_q, stride_q);
    end
  end

  assign addr_o   = addr_q;
  assign stride_o = stride_q;

endmodule

// File: rtl/vec_strip_agen.sv
module vec_strip_agen #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int MVL    = 64,
  localparam int VL_W  = $clog2(MVL) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  total_len_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic [VL_W-1:0]   strip_len_o,
  output logic              strip_start_o,
  output logic              done_o
);
  import vsa_pkg::*;

  vsa_state_e        st_q, st_d;
  logic [VL_W-1:0]   cur_len_q;
  logic [VL_W-1:0]   elem_left_q;
  logic              any_left;
  logic [VL_W-1:0]   next_len;
  logic [ADDR_W-1:0] stride_q;

  // Named events, also watched by the checker.
  logic start_ok, fire, last_fire, pick, take, empty_pick;

  assign start_ok   = start_i && (st_q == ST_IDLE);
  assign fire       = (st_q == ST_STREAM) && mem_ready_i;
  assign last_fire  = fire && (elem_left_q == VL_W'(1));
  assign pick       = (st_q == ST_PICK) || last_fire;
  assign take       = pick && any_left;
  assign empty_pick = pick && !any_left;

  vsa_strip_plan #(.LEN_W(LEN_W), .MVL(MVL)) u_plan (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_ok),
    .n_i        (total_len_i),
    .take_i     (take),
    .any_left_o (any_left),
    .next_len_o (next_len)
  );

  vsa_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_ok),
    .base_i   (base_i),
    .stride_i (stride_i),
    .step_i   (fire),
    .addr_o   (addr_o),
    .stride_o (stride_q)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (start_ok) st_d = ST_PICK;
      ST_PICK:     st_d = any_left ? ST_ANNOUNCE : ST_DONE;
      ST_ANNOUNCE: st_d = ST_STREAM;
      ST_STREAM:   if (last_fire) st_d = any_left ? ST_ANNOUNCE : ST_DONE;
      ST_DONE:     st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_len_q   <= '0;
      elem_left_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        cur_len_q   <= next_len;
        elem_left_q <= next_len;
      end else if (fire) begin
        elem_left_q <= elem_left_q - 1'b1;
      end
    end
  end

  assign addr_valid_o  = (st_q == ST_STREAM);
  assign strip_start_o = (st_q == ST_ANNOUNCE);
  assign done_o        = (st_q == ST_DONE);
  assign strip_len_o   = cur_len_q;

endmodule

// File: rtl/vsa_chk.sv
module vsa_chk #(
  parameter int ADDR_W = 24,
  parameter int VL_W   = 7,
  parameter int MVL    = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic              ready,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] stride_q,
  input logic [VL_W-1:0]   len,
  input logic              sstart,
  input logic              done,
  input logic              fire,
  input logic              last_fire,
  input logic              empty_pick
);

  a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(addr));

  a_r4_step_by_stride: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> addr == ADDR_W'($past(addr) + $past(stride_q)));

  a_r8_announce_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && sstart));

  a_r8_announce_then_stream: assert property (@(posedge clk) disable iff (!rst_n)
    sstart |=> valid && !sstart);

  a_r2_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sstart |-> (len != '0) && (len <= VL_W'(MVL)));

  a_r2_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $stable(len));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last_fire) || $past(empty_pick));

endmodule

bind vec_strip_agen vsa_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W), .MVL(MVL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .valid      (addr_valid_o),
  .ready      (mem_ready_i),
  .addr       (addr_o),
  .stride_q   (stride_q),
  .len        (strip_len_o),
  .sstart     (strip_start_o),
  .done       (done_o),
  .fire       (fire),
  .last_fire  (last_fire),
  .empty_pick (empty_pick)
);

// File: tb/tb_vec_strip_agen.sv
module tb_vec_strip_agen;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;
  localparam int MVL    = 64;
  localparam int VL_W   = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              start_i;
  logic [LEN_W-1:0]  total_len_i;
  logic [ADDR_W-1:0] base_i;
  logic [ADDR_W-1:0] stride_i;
  logic              mem_ready_i;
  logic [ADDR_W-1:0] addr_o;
  logic              addr_valid_o;
  logic [VL_W-1:0]   strip_len_o;
  logic              strip_start_o;
  logic              done_o;

  int checks = 0;
  int fails  = 0;

  vec_strip_agen dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit rdy(input int pat, input int cyc);
    if (pat == 0) return 1'b1;
    if (pat == 1) return (cyc % 3) != 0;
    return (cyc % 2) == 0;
  endfunction

  function automatic int exp_len(input int n, input int idx);
    if ((n % MVL) != 0 && idx == 0) return n % MVL;
    return MVL;
  endfunction

  function automatic longint exp_addr(input longint base, input longint stride, input int k);
    return (base + longint'(k) * stride) & 64'hFFFFFF;
  endfunction

  task automatic run(input int n, input longint base, input longint stride,
                     input int pat, input bit inject);
    int nstr, sidx, k, elem, done_seen, cur;
    bit prev_last, prev_ss;
    nstr = n / MVL + (((n % MVL) != 0) ? 1 : 0);
    sidx = 0; k = 0; elem = 0; done_seen = 0; cur = 0;
    prev_last = 1'b0; prev_ss = 1'b0;
    @(negedge clk);
    start_i = 1'b1; total_len_i = LEN_W'(n);
    base_i = ADDR_W'(base); stride_i = ADDR_W'(stride);
    @(negedge clk);
    start_i = 1'b0;
    total_len_i = 16'h0005; base_i = 24'h123456; stride_i = 24'h000777;
    for (int cyc = 1; cyc < 3000; cyc++) begin
      mem_ready_i = rdy(pat, cyc);
      start_i = inject && (cyc == 10 || cyc == 40);
      if (cyc == 1)
        chk(!strip_start_o && !done_o && !addr_valid_o, "R8", "quiet pick cycle", 0, 0);
      if (cyc == 2) begin
        if (nstr > 0) chk(strip_start_o, "R8", "first strip pulse at cycle 2", strip_start_o, 1);
        else          chk(done_o, "R3", "empty done at cycle 2", done_o, 1);
      end
      if (prev_ss) chk(addr_valid_o, "R8", "valid after strip pulse", addr_valid_o, 1);
      if (strip_start_o) begin
        chk(!addr_valid_o, "R8", "no valid on strip pulse", addr_valid_o, 0);
        chk(sidx < nstr, "R3", "strip count", sidx + 1, nstr);
        if (sidx > 0) chk(elem == cur, "R2", "elements in strip", elem, cur);
        cur = exp_len(n, sidx);
        chk(int'(strip_len_o) == cur, "R2", "strip length", strip_len_o, cur);
        sidx++; elem = 0;
      end
      prev_last = 1'b0;
      if (addr_valid_o) begin
        chk(int'(strip_len_o) == cur, "R2", "length held", strip_len_o, cur);
        chk(k < n, "R2", "element beyond N", k, n);
        chk(longint'(addr_o) == exp_addr(base, stride, k), "R4", "element address",
            addr_o, exp_addr(base, stride, k));
        if (mem_ready_i) begin
          k++; elem++;
          prev_last = (k == n);
        end
      end
      if (done_o) begin
        chk(done_seen == 0, "R6", "single done", done_seen, 0);
        chk(k == n, "R6", "accepted count at done", k, n);
        chk(sidx == nstr, "R2", "strips at done", sidx, nstr);
        if (n > 0) chk(elem == cur, "R2", "last strip elements", elem, cur);
        done_seen++;
        cyc = 2990;
      end
      prev_ss = strip_start_o;
      @(negedge clk);
      if (prev_last)
        chk(done_o, "R6", "done right after final accept", done_o, 1);
    end
    start_i = 1'b0;
    chk(done_seen == 1, "R6", "transfer completed", done_seen, 1);
    if (inject) chk(k == n, "R7", "start while busy ignored", k, n);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lens [10] = '{0, 1, 2, 63, 64, 65, 127, 128, 129, 200};
    longint strides [3] = '{1, 3, 64'hFFFFFF};
    rst_n = 1'b0; start_i = 1'b0; total_len_i = '0;
    base_i = '0; stride_i = '0; mem_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!addr_valid_o && !strip_start_o && !done_o && strip_len_o == '0,
        "R1", "outputs in reset", {addr_valid_o, strip_start_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!addr_valid_o && !strip_start_o && !done_o && strip_len_o == '0,
        "R1", "outputs after reset", {addr_valid_o, strip_start_o, done_o}, 0);
    for (int li = 0; li < 10; li++) begin
      for (int si = 0; si < 3; si++) begin
        run(lens[li], (si == 1) ? 64'hFFFFF8 : 64'h000100 * li, strides[si],
            (li + si) % 3, 1'b0);
      end
    end
    // R3: exact multiples start with a full strip; R7: mid-run start dropped
    run(128, 64'hFFFFF0, 5, 1, 1'b1);
    run(65, 64'h000040, 64'h000400, 2, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule